// File: doc/BRIEF.md
# Lockup Watchdog Recovery Controller

This block guards a clock generator whose CPU or SRC frequency has just been reprogrammed. While its watchdog is armed it counts cycles, and each heartbeat from the system restarts the count. If no heartbeat arrives within the configured timeout, the block treats the system as hung. It then carries out one frequency recovery action, followed by a system reset pulse.

The action depends on three things: a recovery-mode field, an auto-recovery enable, and the frequency mode in force. Automatic recovery restores the N/M pair that was active before the latest reprogramming. Manual recovery loads a stored recovery N. A third option asks the clock logic to fall back to the hardware straps. The last option issues only the reset. In table-select mode only the fallback to hardware is allowed, and the SRC channel never gets a frequency action. After it has fired, the block stays inert until its watchdog enable is removed and applied again.

Top module: `lockup_recovery_ctrl`

## Requirements
- R1: Once reset is released, rec_load_o, hw_revert_o and sys_rst_o are all low, and so are rec_n_o and rec_m_o.
- R2: With wdt_en_i high, kick_i low and the block armed, the frequency action appears in the cycle that follows TIMEOUT consecutive such clock edges.
- R3: A kick_i pulse restarts the timeout count. A kick present on the edge where the count would expire prevents the firing, and a full TIMEOUT of quiet edges is then needed again.
- R4: While wdt_en_i is low the block never fires, and the count is held at zero.
- R5: The requested method is taken as follows. auto_en_i=1 selects automatic. Otherwise rec_mode_i=00 selects reset-only, 01 selects manual, and 10 or 11 selects hardware fallback.
- R6: Automatic recovery pulses rec_load_o for one cycle. rec_n_o and rec_m_o then carry the pair that was active before the most recent prog_i strobe.
- R7: Manual recovery pulses rec_load_o for one cycle. rec_n_o then equals man_n_i, and rec_m_o equals the currently active M.
- R8: Hardware fallback pulses hw_revert_o for one cycle, and rec_load_o stays low.
- R9: With freq_mode_i=01 (table select), automatic and manual requests become hardware fallback, and reset-only stays reset-only.
- R10: The block raises neither strobe with freq_mode_i=00 or 11 (hardware), or with freq_mode_i=10 (direct) when chan_src_i=1 (SRC channel). Only the reset is issued.
- R11: Every firing, reset-only included, drives sys_rst_o high for exactly RST_W cycles. The pulse starts in the cycle after the action cycle.
- R12: After a firing no further action or reset occurs while wdt_en_i stays high. The block re-arms only after wdt_en_i has been seen low.
- R13: rec_load_o and hw_revert_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdt_en_i | input | 1 | Arms the watchdog |
| kick_i | input | 1 | Heartbeat that restarts the timeout |
| rec_mode_i | input | 2 | Requested recovery method |
| auto_en_i | input | 1 | Selects automatic recovery |
| man_n_i | input | N_W | Stored manual recovery N |
| freq_mode_i | input | 2 | 00 hardware, 01 table select, 10 direct N/M, 11 hardware |
| chan_src_i | input | 1 | 0 CPU channel, 1 SRC channel |
| prog_i | input | 1 | Strobe: a new N/M pair is applied |
| new_n_i | input | N_W | N of the pair being applied |
| new_m_i | input | M_W | M of the pair being applied |
| rec_n_o | output | N_W | Recovery N, valid with rec_load_o |
| rec_m_o | output | M_W | Recovery M, valid with rec_load_o |
| rec_load_o | output | 1 | One-cycle load strobe for rec_n_o/rec_m_o |
| hw_revert_o | output | 1 | One-cycle request to fall back to hardware settings |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
A heartbeat can arrive on the very edge where the timeout would expire, so restarting the count and firing compete in one cycle. The bench raises kick_i so that it is sampled on the TIMEOUT-th quiet edge. It then checks that no strobe or reset appears. After that it requires a fresh full window of quiet edges before the action is observed. Random scenarios also place prog_i strobes just before arming, which checks that the restored pair follows the latest reprogramming.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
  typedef enum logic [1:0] {
    FM_HW     = 2'b00,
    FM_TABLE  = 2'b01,
    FM_DIRECT = 2'b10,
    FM_RSVD   = 2'b11
  } freq_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_AUTO = 2'd1,
    ACT_MAN  = 2'd2,
    ACT_HW   = 2'd3
  } rec_act_e;

  typedef enum logic [1:0] {
    ST_WATCH = 2'd0,
    ST_ACT   = 2'd1,
    ST_RST   = 2'd2,
    ST_DONE  = 2'd3
  } ctl_st_e;
endpackage

// File: rtl/lrc_timeout.sv
module lrc_timeout #(
  parameter int TIMEOUT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic kick_i,
  output logic expire_o
);
  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && !kick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || kick_i)   cnt_q <= '0;
    else if (expire_o)           cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  // R4
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));

  // R3
  kick_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (cnt_q == '0));
endmodule

// File: rtl/lrc_pair_track.sv
module lrc_pair_track #(
  parameter int N_W = 9,
  parameter int M_W = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           prog_i,
  input  logic [N_W-1:0] new_n_i,
  input  logic [M_W-1:0] new_m_i,
  output logic [N_W-1:0] act_n_o,
  output logic [M_W-1:0] act_m_o,
  output logic [N_W-1:0] prv_n_o,
  output logic [M_W-1:0] prv_m_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_n_o <= '0;
      act_m_o <= '0;
      prv_n_o <= '0;
      prv_m_o <= '0;
    end else if (prog_i) begin
      prv_n_o <= act_n_o;
      prv_m_o <= act_m_o;
      act_n_o <= new_n_i;
      act_m_o <= new_m_i;
    end
  end

  // R6
  prev_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i |=> (prv_n_o == $past(act_n_o)) && (prv_m_o == $past(act_m_o)));
endmodule

// File: rtl/lrc_policy.sv
module lrc_policy
  import lrc_pkg::*;
(
  input  logic       auto_en_i,
  input  logic [1:0] rec_mode_i,
  input  logic [1:0] freq_mode_i,
  input  logic       chan_src_i,
  output rec_act_e   act_o
);
  rec_act_e req;
  freq_mode_e fm;

  assign fm = freq_mode_e'(freq_mode_i);

  always_comb begin
    if (auto_en_i)               req = ACT_AUTO;
    else if (rec_mode_i[1])      req = ACT_HW;
    else if (rec_mode_i[0])      req = ACT_MAN;
    else                         req = ACT_NONE;
  end

  always_comb begin
    unique case (fm)
      FM_DIRECT: act_o = chan_src_i ? ACT_NONE : req;
      // table select: only hardware fallback is safe for the output divider
      FM_TABLE:  act_o = (req == ACT_NONE) ? ACT_NONE : ACT_HW;
      default:   act_o = ACT_NONE;
    endcase
  end
endmodule

// File: rtl/lockup_recovery_ctrl.sv
module lockup_recovery_ctrl
  import lrc_pkg::*;
#(
  parameter int N_W     = 9,
  parameter int M_W     = 7,
  parameter int TIMEOUT = 64,
  parameter int RST_W   = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wdt_en_i,
  input  logic           kick_i,
  input  logic [1:0]     rec_mode_i,
  input  logic           auto_en_i,
  input  logic [N_W-1:0] man_n_i,
  input  logic [1:0]     freq_mode_i,
  input  logic           chan_src_i,
  input  logic           prog_i,
  input  logic [N_W-1:0] new_n_i,
  input  logic [M_W-1:0] new_m_i,
  output logic [N_W-1:0] rec_n_o,
  output logic [M_W-1:0] rec_m_o,
  output logic           rec_load_o,
  output logic           hw_revert_o,
  output logic           sys_rst_o
);
  localparam int RCW = (RST_W > 1) ? $clog2(RST_W) : 1;
  localparam logic [RCW-1:0] RLAST = RCW'(RST_W - 1);

  ctl_st_e         st_q;
  rec_act_e        act_q, pol_act;
  logic [N_W-1:0]  n_q, act_n, prv_n;
  logic [M_W-1:0]  m_q, act_m, prv_m;
  logic [RCW-1:0]  rcnt_q;
  logic            run, expire;

  assign run = (st_q == ST_WATCH) && wdt_en_i;

  lrc_timeout #(.TIMEOUT(TIMEOUT)) u_timeout (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .kick_i   (kick_i),
    .expire_o (expire)
  );

  lrc_pair_track #(.N_W(N_W), .M_W(M_W)) u_pairs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .prog_i  (prog_i),
    .new_n_i (new_n_i),
    .new_m_i (new_m_i),
    .act_n_o (act_n),
    .act_m_o (act_m),
    .prv_n_o (prv_n),
    .prv_m_o (prv_m)
  );

  lrc_policy u_policy (
    .auto_en_i   (auto_en_i),
    .rec_mode_i  (rec_mode_i),
    .freq_mode_i (freq_mode_i),
    .chan_src_i  (chan_src_i),
    .act_o       (pol_act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_WATCH;
      act_q  <= ACT_NONE;
      n_q    <= '0;
      m_q    <= '0;
      rcnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_WATCH: if (expire) begin
          st_q  <= ST_ACT;
          act_q <= pol_act;
          unique case (pol_act)
            ACT_AUTO: begin n_q <= prv_n;   m_q <= prv_m; end
            ACT_MAN:  begin n_q <= man_n_i; m_q <= act_m; end
            default:  begin n_q <= '0;      m_q <= '0;    end
          endcase
        end
        ST_ACT: begin
          st_q   <= ST_RST;
          rcnt_q <= '0;
        end
        ST_RST: begin
          if (rcnt_q == RLAST) st_q <= ST_DONE;
          else                 rcnt_q <= rcnt_q + 1'b1;
        end
        ST_DONE: if (!wdt_en_i) st_q <= ST_WATCH;
        default: st_q <= ST_WATCH;
      endcase
    end
  end

  assign rec_n_o     = n_q;
  assign rec_m_o     = m_q;
  assign rec_load_o  = (st_q == ST_ACT) && ((act_q == ACT_AUTO) || (act_q == ACT_MAN));
  assign hw_revert_o = (st_q == ST_ACT) && (act_q == ACT_HW);
  assign sys_rst_o   = (st_q == ST_RST);

  // R13
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rec_load_o && hw_revert_o));

  // R11
  rst_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_load_o || hw_revert_o) |=> sys_rst_o);

  // R8
  hw_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_revert_o |=> !hw_revert_o);

  // R6
  load_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_load_o |=> !rec_load_o);

  // R12
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_DONE) && wdt_en_i) |=> !rec_load_o && !hw_revert_o && !sys_rst_o);

  // R9
  table_hw_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_mode_i == 2'b01) |-> ((pol_act != ACT_AUTO) && (pol_act != ACT_MAN)));

  // R4
  no_fire_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_WATCH) && !wdt_en_i) |=> (st_q == ST_WATCH));
endmodule

// File: tb/tb_lockup_recovery_ctrl.sv
`timescale 1ns/1ps
module tb_lockup_recovery_ctrl;
  localparam int N_W = 9;
  localparam int M_W = 7;
  localparam int TO  = 8;
  localparam int RW  = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wdt_en = 1'b0, kick = 1'b0, auto_en = 1'b0, chan_src = 1'b0, prog = 1'b0;
  logic [1:0]     rec_mode = 2'b00, freq_mode = 2'b00;
  logic [N_W-1:0] man_n = '0, new_n = '0;
  logic [M_W-1:0] new_m = '0;
  logic [N_W-1:0] rec_n;
  logic [M_W-1:0] rec_m;
  logic           rec_load, hw_revert, sys_rst;

  always #2 clk = ~clk;

  lockup_recovery_ctrl #(.N_W(N_W), .M_W(M_W), .TIMEOUT(TO), .RST_W(RW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wdt_en_i(wdt_en), .kick_i(kick),
    .rec_mode_i(rec_mode), .auto_en_i(auto_en), .man_n_i(man_n),
    .freq_mode_i(freq_mode), .chan_src_i(chan_src), .prog_i(prog),
    .new_n_i(new_n), .new_m_i(new_m), .rec_n_o(rec_n), .rec_m_o(rec_m),
    .rec_load_o(rec_load), .hw_revert_o(hw_revert), .sys_rst_o(sys_rst)
  );

  int checks = 0, fails = 0;
  int mn_act = 0, mm_act = 0, mn_prv = 0, mm_prv = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // 0 none, 1 auto, 2 manual, 3 hardware
  function automatic int exp_act(input bit a, input int md, input int fm, input bit src);
    int base;
    base = a ? 1 : (md >= 2) ? 3 : (md == 1) ? 2 : 0;
    if (fm == 2) return src ? 0 : base;
    if (fm == 1) return (base == 0) ? 0 : 3;
    return 0;
  endfunction

  task automatic do_prog(input int n, input int m);
    @(negedge clk);
    prog = 1'b1; new_n = N_W'(n); new_m = M_W'(m);
    @(negedge clk);
    prog = 1'b0;
    mn_prv = mn_act; mm_prv = mm_act;
    mn_act = n % (1 << N_W); mm_act = m % (1 << M_W);
  endtask

  task automatic quiet(input int cyc, input string req);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      chk(!rec_load && !hw_revert && !sys_rst, req, "quiet {load,hw,rst}",
          {rec_load, hw_revert, sys_rst}, 0);
    end
  endtask

  // wdt_en already high with kick low from the current negedge
  task automatic expect_fire(input int e, input int en, input int em, input string req);
    quiet(TO - 1, "R2");
    @(negedge clk);
    chk(rec_load == (e == 1 || e == 2), req, "rec_load", rec_load, int'(e == 1 || e == 2));
    chk(hw_revert == (e == 3), req, "hw_revert", hw_revert, int'(e == 3));
    chk(!sys_rst, "R11", "rst in action cycle", sys_rst, 0);
    if (e == 1 || e == 2) begin
      chk(rec_n == N_W'(en), req, "rec_n", rec_n, en);
      chk(rec_m == M_W'(em), req, "rec_m", rec_m, em);
    end
    for (int i = 0; i < RW; i++) begin
      @(negedge clk);
      chk(sys_rst && !rec_load && !hw_revert, "R11", "rst pulse", sys_rst, 1);
    end
    @(negedge clk);
    chk(!sys_rst, "R11", "rst end", sys_rst, 0);
    quiet(TO + 3, "R12");
  endtask

  task automatic scenario(input bit a, input int md, input int fm, input bit src, input int mn);
    int e, en, em;
    @(negedge clk);
    wdt_en = 1'b0; kick = 1'b0;
    auto_en = a; rec_mode = 2'(md); freq_mode = 2'(fm); chan_src = src; man_n = N_W'(mn);
    @(negedge clk);
    wdt_en = 1'b1;
    e  = exp_act(a, md, fm, src);
    en = (e == 1) ? mn_prv : (mn % (1 << N_W));
    em = (e == 1) ? mm_prv : mm_act;
    expect_fire(e, en, em, (e == 1) ? "R6" : (e == 2) ? "R7" : (e == 3) ? ((fm == 1) ? "R9" : "R8") : "R10");
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rec_load && !hw_revert && !sys_rst && rec_n == '0 && rec_m == '0, "R1", "reset outputs",
        {rec_load, hw_revert, sys_rst}, 0);

    // R4: disabled watchdog never fires
    quiet(3 * TO, "R4");

    do_prog(100, 20);
    do_prog(150, 30);

    // R3: periodic kicks keep it alive
    @(negedge clk); wdt_en = 1'b1; auto_en = 1'b1; freq_mode = 2'b10; chan_src = 1'b0;
    for (int k = 0; k < 4; k++) begin
      quiet(TO - 2, "R3");
      @(negedge clk); kick = 1'b1;
      chk(!rec_load && !hw_revert && !sys_rst, "R3", "kicked", rec_load, 0);
      @(negedge clk); kick = 1'b0;
    end
    // R3: kick on the expiring edge
    @(negedge clk); wdt_en = 1'b0;
    @(negedge clk); wdt_en = 1'b1;
    quiet(TO - 2, "R3");
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    chk(!rec_load && !hw_revert && !sys_rst, "R3", "kick on expiring edge", rec_load, 0);
    expect_fire(1, mn_prv, mm_prv, "R3");

    // R4: disabling midway clears the count
    @(negedge clk); wdt_en = 1'b0;
    @(negedge clk); wdt_en = 1'b1;
    quiet(TO - 2, "R4");
    @(negedge clk); wdt_en = 1'b0;
    quiet(2, "R4");
    @(negedge clk); wdt_en = 1'b1;
    expect_fire(1, mn_prv, mm_prv, "R4");

    // directed method coverage (R5)
    scenario(1'b0, 0, 2, 1'b0, 5);   // R5 reset-only
    scenario(1'b0, 1, 2, 1'b0, 77);  // R7 manual
    scenario(1'b0, 2, 2, 1'b0, 9);   // R8 hw
    scenario(1'b0, 3, 2, 1'b0, 9);   // R5 11 -> hw
    scenario(1'b1, 1, 1, 1'b0, 3);   // R9 auto in table
    scenario(1'b0, 1, 1, 1'b0, 3);   // R9 manual in table
    scenario(1'b0, 0, 1, 1'b0, 3);   // R9 reset-only stays
    scenario(1'b1, 2, 2, 1'b1, 3);   // R10 SRC direct
    scenario(1'b1, 1, 0, 1'b0, 3);   // R10 hardware mode
    scenario(1'b0, 2, 3, 1'b0, 3);   // R10 mode 11

    // R12: staying enabled after firing keeps it inert
    quiet(2 * TO, "R12");

    for (int r = 0; r < 30; r++) begin
      int np;
      np = $urandom_range(0, 2);
      for (int p = 0; p < np; p++) do_prog($urandom_range(0, 511), $urandom_range(0, 127));
      scenario(1'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(0, 3),
               1'($urandom_range(0, 1)), $urandom_range(0, 511));
    end

    summary();
    $finish;
  end
endmodule